// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard controller of a five-stage in-order pipeline with fetch, decode/register-read, execute, memory and write-back stages. It is purely combinational. Its inputs are the two source register numbers of the instruction in decode, and the destination number and register-write flag of each of the two older instructions still in flight (memory stage and write-back stage). It also takes a load marker for the memory-stage instruction and a flag that says a jump or taken branch is changing the PC.

From these inputs it drives three kinds of output. It picks the source of each ALU operand: register file, write-back result or memory-stage ALU result. It freezes the front of the pipe for one cycle when a loaded value is needed too early, and injects a bubble behind the frozen instructions. It clears the two wrong-path slots when the PC is redirected.

When no hazard is present, the enable and clear defaults supplied by the surrounding pipeline pass through unchanged. Single-stepping and similar control therefore keeps working.

Top module: `hazard_ctl`

## Requirements
- R1: Each operand selector is 2 bits wide and uses this encoding: 0 = register-file value, 1 = write-back-stage result, 2 = memory-stage ALU result. The value 3 is never produced. A memory-stage destination that equals the operand's source register, with its write flag set, gives 2.
- R2: When the memory stage gives no hit, a write-back-stage destination that equals the source register, with its write flag set, gives 1. Operand A uses decode source 0 and operand B uses decode source 1.
- R3: A destination match counts for forwarding or stalling only if that stage's write flag is 1.
- R4: When both older stages write the operand's source register, the selector is 2, because the memory-stage producer is newer.
- R5: Register number 0, as a source or as a destination, never causes forwarding (selector 0) and never causes a stall.
- R6: A load in the memory stage with its write flag set, whose destination equals either decode source, raises a stall. During a stall, and with no redirect, the PC enable, fetch/decode enable and decode/execute enable are 0 and the execute/memory clear is 1.
- R7: With no active stall, the PC enable equals the default enable and the execute/memory clear equals the default clear. The fetch/decode and decode/execute enables are 1.
- R8: With the redirect flag at 1, the fetch/decode and decode/execute clears are both 1. With the redirect flag at 0, both take the default clear.
- R9: If a redirect and a load-use stall are raised together, the redirect wins. The enables take their R7 values, the execute/memory clear equals the default clear, and both flush clears are 1.
- R10: Every output is a function of the current inputs only. The same input vector gives the same outputs whatever was applied before it and however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | RW | Source register 0 of the decoding instruction |
| dec_src_b | input | RW | Source register 1 of the decoding instruction |
| mem_dst | input | RW | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | RW | Destination register of the write-back-stage instruction |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| redirect | input | 1 | Jump or taken branch is redirecting the PC |
| dflt_en | input | 1 | Default enable used when nothing stalls |
| dflt_clr | input | 1 | Default clear used when nothing stalls or flushes |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| pc_en | output | 1 | PC register enable |
| fd_en | output | 1 | Fetch/decode register enable |
| de_en | output | 1 | Decode/execute register enable |
| fd_clr | output | 1 | Fetch/decode register clear |
| de_clr | output | 1 | Decode/execute register clear |
| em_clr | output | 1 | Execute/memory register clear |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the load-use stall and the redirect flush. The bench provokes both together by presenting a writing load whose destination matches a decode source while the redirect flag is high. It judges the outcome by requiring default enables, default execute/memory clear and both flush clears at 1. The second pair is forwarding from both older stages at once. This is forced by giving both the same destination with both write flags set, and the selectors must then show the memory-stage code rather than the write-back code.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_is_load,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  input  logic          redirect,
  input  logic          dflt_en,
  input  logic          dflt_clr,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          pc_en,
  output logic          fd_en,
  output logic          de_en,
  output logic          fd_clr,
  output logic          de_clr,
  output logic          em_clr
);
  localparam logic [1:0] SEL_RF  = 2'd0;
  localparam logic [1:0] SEL_WB  = 2'd1;
  localparam logic [1:0] SEL_MEM = 2'd2;

  logic mem_live, wb_live;
  logic a_mem, b_mem, a_wb, b_wb;
  logic load_use, freeze;

  assign mem_live = mem_wr && (mem_dst != '0);
  assign wb_live  = wb_wr  && (wb_dst  != '0);

  assign a_mem = mem_live && (dec_src_a == mem_dst);
  assign b_mem = mem_live && (dec_src_b == mem_dst);
  assign a_wb  = wb_live  && (dec_src_a == wb_dst);
  assign b_wb  = wb_live  && (dec_src_b == wb_dst);

  assign sel_a = a_mem ? SEL_MEM : (a_wb ? SEL_WB : SEL_RF);
  assign sel_b = b_mem ? SEL_MEM : (b_wb ? SEL_WB : SEL_RF);

  assign load_use = mem_is_load && (a_mem || b_mem);
  assign freeze   = load_use && !redirect;

  assign pc_en  = freeze ? 1'b0 : dflt_en;
  assign fd_en  = !freeze;
  assign de_en  = !freeze;
  assign em_clr = freeze ? 1'b1 : dflt_clr;

  assign fd_clr = redirect ? 1'b1 : dflt_clr;
  assign de_clr = redirect ? 1'b1 : dflt_clr;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int RW = 5
) (
  input logic [RW-1:0] dec_src_a,
  input logic [RW-1:0] dec_src_b,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wr,
  input logic          mem_is_load,
  input logic [RW-1:0] wb_dst,
  input logic          wb_wr,
  input logic          redirect,
  input logic          dflt_en,
  input logic          dflt_clr,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic          pc_en,
  input logic          fd_en,
  input logic          de_en,
  input logic          fd_clr,
  input logic          de_clr,
  input logic          em_clr
);
  logic both_a, ld_hit;
  assign both_a = mem_wr && wb_wr && (mem_dst == wb_dst) && (mem_dst == dec_src_a) && (mem_dst != '0);
  assign ld_hit = mem_is_load && mem_wr && (mem_dst != '0) &&
                  ((mem_dst == dec_src_a) || (mem_dst == dec_src_b));

  always_comb begin
    AST_SEL_CODE: assert (sel_a != 2'd3 && sel_b != 2'd3); // R1
    AST_NO_WRITE_NO_FWD: assert (mem_wr || wb_wr || (sel_a == 2'd0 && sel_b == 2'd0)); // R3
    AST_NEWEST_WINS: assert (!both_a || sel_a == 2'd2); // R4
    AST_ZERO_SRC: assert (dec_src_a != '0 || sel_a == 2'd0); // R5
    AST_STALL_SET: assert (!(ld_hit && !redirect) || (!pc_en && !fd_en && !de_en && em_clr)); // R6
    AST_FREEZE_TOGETHER: assert (fd_en == de_en && (fd_en || em_clr)); // R7
    AST_FLUSH_PAIR: assert (!redirect || (fd_clr && de_clr)); // R8
    AST_REDIRECT_WINS: assert (!redirect || (fd_en && de_en && pc_en == dflt_en && em_clr == dflt_clr)); // R9
  end
endmodule

bind hazard_ctl hazard_ctl_chk #(.RW(RW)) u_chk (
  .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .mem_dst(mem_dst), .mem_wr(mem_wr),
  .mem_is_load(mem_is_load), .wb_dst(wb_dst), .wb_wr(wb_wr), .redirect(redirect),
  .dflt_en(dflt_en), .dflt_clr(dflt_clr), .sel_a(sel_a), .sel_b(sel_b), .pc_en(pc_en),
  .fd_en(fd_en), .de_en(de_en), .fd_clr(fd_clr), .de_clr(de_clr), .em_clr(em_clr)
);

// File: tb/tb_hazard_ctl.sv
module tb_hazard_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] dec_src_a, dec_src_b, mem_dst, wb_dst;
  logic mem_wr, mem_is_load, wb_wr, redirect, dflt_en, dflt_clr;
  logic [1:0] sel_a, sel_b;
  logic pc_en, fd_en, de_en, fd_clr, de_clr, em_clr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  hazard_ctl #(.RW(5)) dut (
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .mem_is_load(mem_is_load), .wb_dst(wb_dst), .wb_wr(wb_wr), .redirect(redirect),
    .dflt_en(dflt_en), .dflt_clr(dflt_clr), .sel_a(sel_a), .sel_b(sel_b), .pc_en(pc_en),
    .fd_en(fd_en), .de_en(de_en), .fd_clr(fd_clr), .de_clr(de_clr), .em_clr(em_clr)
  );

  // stimulus {src_a,src_b,mem_dst,mem_wr,wb_dst,wb_wr,load,redirect,dflt_en,dflt_clr}
  // expect   {sel_a,sel_b,pc_en,fd_en,de_en,fd_clr,de_clr,em_clr}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {5'd1,  5'd2,  5'd2,  1'b1, 5'd1,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd2, 6'b111000},
    {5'd10, 5'd10, 5'd10, 1'b1, 5'd10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 6'b111000},
    {5'd3,  5'd4,  5'd3,  1'b0, 5'd4,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 6'b111000},
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 6'b111000},
    {5'd7,  5'd8,  5'd8,  1'b1, 5'd7,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 2'd2, 6'b000001},
    {5'd5,  5'd9,  5'd5,  1'b1, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 6'b000111},
    {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 6'b011111},
    {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 6'b111110},
    {5'd6,  5'd6,  5'd6,  1'b1, 5'd6,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 2'd2, 6'b111110},
    {5'd12, 5'd13, 5'd12, 1'b1, 5'd13, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 6'b000001},
    {5'd31, 5'd31, 5'd31, 1'b0, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 2'd1, 6'b111000},
    {5'd4,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 6'b111000}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2";  1: return "R4";  2: return "R3";  3: return "R5";
      4: return "R6";  5: return "R6";  6: return "R7";  7: return "R8";
      8: return "R9";  9: return "R1";  10: return "R3"; default: return "R5";
    endcase
  endfunction

  function automatic logic [9:0] ref_model(input logic [25:0] s);
    logic [4:0] a, b, md, wd;
    logic mw, ww, ld, rd, de, dc, am, bm, aw, bw, st;
    logic [1:0] sa, sb;
    {a, b, md, mw, wd, ww, ld, rd, de, dc} = s;
    am = mw && md != 0 && md == a;
    bm = mw && md != 0 && md == b;
    aw = ww && wd != 0 && wd == a;
    bw = ww && wd != 0 && wd == b;
    sa = am ? 2'd2 : (aw ? 2'd1 : 2'd0);
    sb = bm ? 2'd2 : (bw ? 2'd1 : 2'd0);
    st = ld && (am || bm) && !rd;
    return {sa, sb, st ? 1'b0 : de, !st, !st, rd | dc, rd | dc, st | dc};
  endfunction

  function automatic logic [9:0] observed();
    return {sel_a, sel_b, pc_en, fd_en, de_en, fd_clr, de_clr, em_clr};
  endfunction

  task automatic drive(input logic [25:0] s);
    @(negedge clk);
    {dec_src_a, dec_src_b, mem_dst, mem_wr, wb_dst, wb_wr, mem_is_load, redirect, dflt_en, dflt_clr} = s;
    #1;
  endtask

  task automatic check(input string tag, input logic [9:0] exp);
    checks++;
    if (observed() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, observed(), exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    {dec_src_a, dec_src_b, mem_dst, mem_wr, wb_dst, wb_wr, mem_is_load, redirect, dflt_en, dflt_clr} = '0;
    dflt_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R7 idle under reset", 10'b00_00_111000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35:10]);
      check(vec_tag(i), VEC[i][9:0]);
    end

    // R10: hold a vector over several edges, then revisit an earlier vector
    drive(VEC[4][35:10]);
    repeat (3) @(posedge clk);
    #1;
    check("R10 held stall", VEC[4][9:0]);
    drive(VEC[8][35:10]);
    drive(VEC[0][35:10]);
    check("R10 revisit", VEC[0][9:0]);

    // R2: operand B from write-back with no memory hit
    drive({5'd0, 5'd9, 5'd3, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    check("R2 operand B", 10'b00_01_111000);

    // R1/R6 model sweep over small register numbers to provoke matches
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 400; n++) begin
      logic [25:0] s;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      s = {2'b00, lfsr[2:0], 2'b00, lfsr[5:3], 2'b00, lfsr[8:6], lfsr[9],
           2'b00, lfsr[12:10], lfsr[13], lfsr[14], lfsr[15] & lfsr[16], lfsr[17], lfsr[18]};
      drive(s);
      check("R1 sweep", ref_model(s));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule